// File: doc/BRIEF.md
# Triggered Capture Sequencer

This block sequences a triggered data capture. After a start command it records a programmed number of samples from before the trigger. It then keeps recording while it waits for a trigger. Once a trigger arrives it records a programmed number of samples after it. A sample counts only on a cycle where the valid-sample strobe is high. The write enable it drives tells a downstream memory datapath which samples to keep.

The block has two modes. In single-shot mode one capture ends the acquisition. In multi-shot mode the block returns to the pre-trigger phase after each capture until the programmed shot count is reached. Each accepted trigger raises a trigger interrupt. Each completed capture raises a shot-done pulse. A normal finish raises one end-of-acquisition interrupt. A stop command aborts at once, from any phase, and raises no end interrupt.

Top module: `trig_capture_seq`

## Requirements
- R1: After reset the block is idle, and `busy`, `wr_en`, `trig_irq`, `trig_flash`, `shot_done` and `end_irq` are all low, whatever the inputs.
- R2: When idle, `start_cmd` begins an acquisition: `busy` is high from the next cycle. While busy, `start_cmd` has no effect. In particular, it does not restart the pre-trigger count.
- R3: The pre-trigger phase counts only the cycles where `sample_vld` is high. It moves to the trigger wait in the cycle after the strobe count reaches `pre_len`. A `pre_len` of 0 gives a pre-trigger phase of exactly one cycle.
- R4: `trig_in` is honoured only during the trigger wait. In that phase, a cycle with `trig_in` high and `stop_cmd` low drives `trig_irq` and `trig_flash` high for that cycle, and the block enters the post-trigger phase. In every other phase `trig_in` produces no pulse.
- R5: The post-trigger phase counts `sample_vld` strobes from zero. Its last cycle is the one where the count reaches `post_len`, with a minimum of one cycle. `shot_done` is high in that last cycle only.
- R6: In single-shot mode (`multi_mode`=0) the block returns to idle after the first shot. `end_irq` is high in the same cycle as that `shot_done`.
- R7: In multi-shot mode the block runs `shot_total` shots, where a value of 0 means 1, and returns to the pre-trigger phase between shots. It raises `trig_irq` once per shot and `end_irq` once, with the final `shot_done`.
- R8: `stop_cmd` returns the block to idle at the next edge from any phase. It takes priority over a start, a trigger or a shot completion in the same cycle, so that cycle shows no `trig_irq`, `shot_done` or `end_irq`.
- R9: `busy` is high exactly while the block is not idle. `wr_en` equals `sample_vld` while busy and is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cmd | input | 1 | Start an acquisition (honoured when idle) |
| stop_cmd | input | 1 | Abort to idle |
| sample_vld | input | 1 | Valid-sample strobe |
| trig_in | input | 1 | Trigger flag |
| multi_mode | input | 1 | 1 = multi-shot, 0 = single-shot |
| pre_len | input | CNT_W | Pre-trigger sample count |
| post_len | input | CNT_W | Post-trigger sample count |
| shot_total | input | SHOT_W | Shots per multi-shot acquisition |
| wr_en | output | 1 | Record current sample |
| shot_done | output | 1 | Pulse in the last cycle of a shot |
| trig_irq | output | 1 | Trigger interrupt pulse |
| end_irq | output | 1 | End-of-acquisition interrupt pulse |
| busy | output | 1 | Acquisition active |
| trig_flash | output | 1 | Trigger indicator pulse |

## Verification
The bench sweeps every combination of small pre-trigger and post-trigger lengths, including zero, with shot counts of 0 to 3 in both modes. For each run it computes the exact cycle of every trigger, shot-done and end pulse. A design that counts `pre_len` off by one, ignores the zero-means-one shot rule, or loops one shot too many shifts or adds pulses, and the cycle-by-cycle comparison catches this.

Directed runs cover three more cases:
- Strobes are withheld while the trigger is held high in the pre-trigger phase. A design that counts cycles instead of strobes, or accepts early triggers, shows this at once.
- A start is issued in the middle of the count. A design that restarts on it delays the trigger pulse.
- A stop arrives in the final post-trigger cycle. A design that lets completion win over the abort raises a false end interrupt.

// File: rtl/trig_capture_seq.sv
module trig_capture_seq #(
  parameter int CNT_W  = 16,
  parameter int SHOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              sample_vld,
  input  logic              trig_in,
  input  logic              multi_mode,
  input  logic [CNT_W-1:0]  pre_len,
  input  logic [CNT_W-1:0]  post_len,
  input  logic [SHOT_W-1:0] shot_total,
  output logic              wr_en,
  output logic              shot_done,
  output logic              trig_irq,
  output logic              end_irq,
  output logic              busy,
  output logic              trig_flash
);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_WAIT, S_POST} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [SHOT_W-1:0] shot_idx;
  logic [CNT_W:0]    cnt_nx;
  logic [SHOT_W:0]   shot_nx;
  logic              pre_done, post_done, more_shots;

  assign cnt_nx     = {1'b0, cnt} + {{CNT_W{1'b0}}, sample_vld};
  assign shot_nx    = {1'b0, shot_idx} + {{SHOT_W{1'b0}}, 1'b1};
  assign pre_done   = cnt_nx >= {1'b0, pre_len};
  assign post_done  = cnt_nx >= {1'b0, post_len};
  assign more_shots = multi_mode && (shot_nx < {1'b0, shot_total});

  assign busy       = (st != S_IDLE);
  assign wr_en      = sample_vld & busy;
  assign trig_irq   = (st == S_WAIT) & trig_in & ~stop_cmd;
  assign trig_flash = trig_irq;
  assign shot_done  = (st == S_POST) & post_done & ~stop_cmd;
  assign end_irq    = shot_done & ~more_shots;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shot_idx <= '0;
    end else if (stop_cmd) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start_cmd) begin
          st       <= S_PRE;
          cnt      <= '0;
          shot_idx <= '0;
        end
        S_PRE: begin
          cnt <= cnt_nx[CNT_W-1:0];
          if (pre_done) st <= S_WAIT;
        end
        S_WAIT: if (trig_in) begin
          st  <= S_POST;
          cnt <= '0;
        end
        default: begin
          if (post_done) begin
            cnt <= '0;
            if (more_shots) begin
              st       <= S_PRE;
              shot_idx <= shot_nx[SHOT_W-1:0];
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt_nx[CNT_W-1:0];
          end
        end
      endcase
    end
  end

endmodule

module trig_capture_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_cmd,
  input logic stop_cmd,
  input logic sample_vld,
  input logic wr_en,
  input logic shot_done,
  input logic trig_irq,
  input logic end_irq,
  input logic busy,
  input logic trig_flash
);

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !busy);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_cmd && !stop_cmd) |=> busy);

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> (busy && trig_flash) ##1 (busy && !trig_irq));

  // R6
  end_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> shot_done);

  // R7
  end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |=> !busy);

  // R5
  done_then_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shot_done && !end_irq) |=> (busy && !trig_irq));

endmodule

bind trig_capture_seq trig_capture_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
  .sample_vld(sample_vld), .wr_en(wr_en), .shot_done(shot_done),
  .trig_irq(trig_irq), .end_irq(end_irq), .busy(busy), .trig_flash(trig_flash)
);

// File: tb/test_trig_capture_seq.sv
module test_trig_capture_seq;
  localparam int CLK_P  = 10;
  localparam int CNT_W  = 8;
  localparam int SHOT_W = 4;

  logic clk = 0, rst_n = 0;
  logic start_cmd = 0, stop_cmd = 0, sample_vld = 0, trig_in = 0, multi_mode = 0;
  logic [CNT_W-1:0]  pre_len = '0, post_len = '0;
  logic [SHOT_W-1:0] shot_total = '0;
  logic wr_en, shot_done, trig_irq, end_irq, busy, trig_flash;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_capture_seq #(.CNT_W(CNT_W), .SHOT_W(SHOT_W)) i_trig_capture_seq (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .sample_vld(sample_vld), .trig_in(trig_in), .multi_mode(multi_mode),
    .pre_len(pre_len), .post_len(post_len), .shot_total(shot_total),
    .wr_en(wr_en), .shot_done(shot_done), .trig_irq(trig_irq),
    .end_irq(end_irq), .busy(busy), .trig_flash(trig_flash));

  function automatic logic [5:0] outs();
    return {busy, wr_en, trig_irq, trig_flash, shot_done, end_irq};
  endfunction

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (busy,wr,tirq,flash,done,end)", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    sample_vld = 1; trig_in = 1; start_cmd = 0;
    tick(); tick();
    #1 chk("R1 held in reset", outs(), 6'b0);
    rst_n = 1;
    tick();
    #1 chk("R1 idle after reset", outs(), 6'b0);

    for (int md = 0; md < 2; md++)
      for (int pr = 0; pr < 4; pr++)
        for (int po = 0; po < 4; po++)
          for (int sh = 0; sh < 4; sh++) begin
            int p, l, s;
            logic [5:0] first_act, first_exp;
            bit bad;
            p = (pr == 0) ? 1 : pr;
            l = p + 1 + ((po == 0) ? 1 : po);
            s = (md == 1) ? ((sh == 0) ? 1 : sh) : 1;
            bad = 0; first_act = '0; first_exp = '0;
            multi_mode = md[0]; pre_len = CNT_W'(pr); post_len = CNT_W'(po);
            shot_total = SHOT_W'(sh);
            sample_vld = 1; trig_in = 1; start_cmd = 1;
            #1 chk("R9 idle with strobe", outs(), 6'b0);
            tick();
            start_cmd = 0;
            for (int c = 0; c < s * l; c++) begin
              logic [5:0] e;
              int k;
              k = c % l;
              e = {1'b1, 1'b1, (k == p), (k == p), (k == l - 1), (c == s * l - 1)};
              #1;
              if (!bad && outs() !== e) begin
                bad = 1; first_act = outs(); first_exp = e;
              end
              tick();
            end
            chk($sformatf("R3 R4 R5 R6 R7 sweep md=%0d pre=%0d post=%0d shots=%0d",
                          md, pr, po, sh), first_act, first_exp);
            #1 chk("R6 R7 idle after end", outs(), 6'b010000 & 6'b0);
          end

    // Strobe gating, trigger ignored before wait, start ignored while busy
    multi_mode = 0; pre_len = 3; post_len = 2; shot_total = 1;
    trig_in = 1; sample_vld = 0; start_cmd = 1;
    tick();
    start_cmd = 0;
    for (int c = 0; c < 5; c++) begin
      #1 chk("R3 R4 no strobe, trigger ignored in pre", outs(), 6'b100000);
      tick();
    end
    sample_vld = 1;
    #1 chk("R3 strobe 1", outs(), 6'b110000);
    tick();
    start_cmd = 1;
    #1 chk("R2 start while busy", outs(), 6'b110000);
    tick();
    start_cmd = 0;
    #1 chk("R3 strobe 3", outs(), 6'b110000);
    tick();
    #1 chk("R2 R4 trigger at expected cycle", outs(), 6'b111100);
    tick();
    stop_cmd = 1;
    #1 chk("R5 post first cycle", outs(), 6'b110000);
    stop_cmd = 0;
    tick();
    #1 chk("R5 post last cycle", outs(), 6'b110011);
    stop_cmd = 1;
    #1 chk("R8 stop beats completion", outs(), 6'b110000);
    tick();
    stop_cmd = 0; sample_vld = 0;
    #1 chk("R8 idle after stop", outs(), 6'b000000);

    // Trigger wait holds while trig_in is low
    pre_len = 0; trig_in = 0; start_cmd = 1;
    tick();
    start_cmd = 0;
    tick();
    for (int c = 0; c < 4; c++) begin
      #1 chk("R4 waiting without trigger", outs(), 6'b100000);
      tick();
    end
    trig_in = 1; stop_cmd = 1;
    #1 chk("R8 stop beats trigger", outs(), 6'b100000);
    tick();
    stop_cmd = 0; trig_in = 0;
    #1 chk("R8 idle after stop in wait", outs(), 6'b000000);

    start_cmd = 1; stop_cmd = 1;
    tick();
    start_cmd = 0; stop_cmd = 0;
    #1 chk("R8 stop beats start", outs(), 6'b000000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule